// File: doc/BRIEF.md
# Expansion Bus Auto-Configuration Responder

This block answers the configuration probes that a host issues to a chain of memory boards on an expansion bus. Each board is handled in turn. While a board is current, byte reads in the configuration window return its identity: type and size, flags, product code, manufacturer code, serial number and diagnostic vector. Each 8-bit register is read as two nibbles, and every nibble arrives on data bits 7:4. All nibbles except those of the type register are inverted.

The host then assigns the board a 32-bit base address. It can do this with whole-byte writes, with a single 16-bit write, or with a mix of nibble writes and byte writes. A latch records whether a nibble write came first, and this changes what the next address-low write loads. A write to address-high completes the board, and so does a write to the stop register. On completion the block publishes the board index and base address for one cycle, then moves on to the next board. After the last board it raises a sticky all-done flag and goes quiet. The per-board RAM flag and size are live inputs, selected by the current board index.

Top module: `autocfg_responder`

## Requirements
- R1: A read returns one nibble on `rdata[7:4]` and zeros on `rdata[3:0]`. It is selected by `addr[7:0]` (register offset) and `addr[8]`: 1 gives the register's low nibble, 0 gives its high nibble.
- R2: Every returned nibble is bitwise inverted, except the nibble of the type register at offset 0x00, which is returned true.
- R3: The type register is {2'b10, ram, 2'b00, size_code}. The size input is e, meaning 2^e KB. For e<6 the code is 1. For 6..12 the code is e-5. For e=13 the code is 0. For 14..20 the code is e-14 (extended). For e>20 the code is the extended fallback 2.
- R4: The flags register (0x08) has bit 7 = ram, bit 5 = extended size (e>13), bit 4 = 1 and all other bits 0.
- R5: The product register (0x04) reads PRODUCT_ID, 0x11 by default. Manufacturer high byte is at 0x10 and low byte at 0x14, taken from MFG_ID. Every other offset, including serial 0x18–0x24 and diagnostic 0x28/0x2C, reads as 0x00.
- R6: A byte write to 0x44 loads base[19:16] from wdata[7:4]. A byte write to 0x50 loads base[27:24] from wdata[7:4]. Both set the nibble latch.
- R7: A byte write to 0x48 with the latch set loads only base[23:20] from wdata[7:4] and clears the latch. With the latch clear it loads base[23:16] from wdata[7:0].
- R8: A byte write to 0x40 loads base[31:24] and completes the board. A word write (`wr_word`=1) to 0x40 loads base[31:16] from wdata and completes the board. base[15:0] is always 0.
- R9: On completion, `cfg_valid` is high for one cycle, on the cycle after the write, with `cfg_index` = current board and `cfg_base` = its base. The working base and the latch are then cleared, and reads reflect the next board's inputs.
- R10: A byte write to 0x4C completes the board and publishes the base as built so far, unchanged.
- R11: After NUM_BOARDS completions, `all_done` stays high. Reads return 0xF0 and writes publish nothing.
- R12: A word write to any offset other than 0x40 changes no state and pulses `word_err` on the next cycle (only while not all done).
- R13: After reset: `all_done`, `cfg_valid` and `word_err` are low, board 0 is current and the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 9 | Bit 8 nibble select, bits 7:0 register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rdata | output | 8 | Read nibble on bits 7:4 |
| board_ram | input | NUM_BOARDS | Per-board RAM flag |
| board_size_exp | input | 5*NUM_BOARDS | Per-board size exponent, 2^e KB |
| cfg_valid | output | 1 | One-cycle completion pulse |
| cfg_index | output | IDX_W | Index of the completed board |
| cfg_base | output | 32 | Base address of the completed board |
| all_done | output | 1 | All boards configured |
| word_err | output | 1 | Unsupported word write pulse |

## Verification
The bench builds the block with NUM_BOARDS=3 and MFG_ID=16'hC3A7. Three boards let it reach a completion in mid-chain, the completion of the last board, and the silent state after all are done, within short write sequences. Random runs reset and start again many times. The manufacturer code has four distinct nibbles, so a swapped byte or swapped nibble shows up. Size exponents are swept over 0 to 31, which reaches both fallback codes and the boundary between base and extended codes at 8 and 16 MB.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;

    localparam logic [7:0] OFS_TYPE    = 8'h00;
    localparam logic [7:0] OFS_PROD    = 8'h04;
    localparam logic [7:0] OFS_FLAGS   = 8'h08;
    localparam logic [7:0] OFS_MFG_HI  = 8'h10;
    localparam logic [7:0] OFS_MFG_LO  = 8'h14;
    localparam logic [7:0] OFS_ADDR_HI = 8'h40;
    localparam logic [7:0] OFS_NIB_LO  = 8'h44;
    localparam logic [7:0] OFS_ADDR_LO = 8'h48;
    localparam logic [7:0] OFS_STOP    = 8'h4C;
    localparam logic [7:0] OFS_NIB_HI  = 8'h50;

    localparam int SIZE_W = 5;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_NIB_LO,
        WR_NIB_HI,
        WR_ADDR_LO,
        WR_ADDR_HI_B,
        WR_ADDR_HI_W,
        WR_STOP,
        WR_BAD_WORD
    } wr_kind_e;

    typedef struct packed {
        logic              ram;
        logic [SIZE_W-1:0] size_exp;
    } board_cfg_t;

    typedef struct packed {
        logic       ext;
        logic [2:0] code;
    } size_enc_t;

    // size exponent e means 2^e KB
    function automatic size_enc_t encode_size(input logic [SIZE_W-1:0] e);
        size_enc_t r;
        if (e < 5'd6) begin
            r.ext  = 1'b0;
            r.code = 3'd1;
        end else if (e <= 5'd12) begin
            r.ext  = 1'b0;
            r.code = 3'(e - 5'd5);
        end else if (e == 5'd13) begin
            r.ext  = 1'b0;
            r.code = 3'd0;
        end else if (e <= 5'd20) begin
            r.ext  = 1'b1;
            r.code = 3'(e - 5'd14);
        end else begin
            r.ext  = 1'b1;
            r.code = 3'd2;
        end
        return r;
    endfunction

    function automatic wr_kind_e classify_write(input logic word, input logic [7:0] ofs);
        wr_kind_e k;
        if (word) begin
            k = (ofs == OFS_ADDR_HI) ? WR_ADDR_HI_W : WR_BAD_WORD;
        end else begin
            case (ofs)
                OFS_NIB_LO:  k = WR_NIB_LO;
                OFS_NIB_HI:  k = WR_NIB_HI;
                OFS_ADDR_LO: k = WR_ADDR_LO;
                OFS_ADDR_HI: k = WR_ADDR_HI_B;
                OFS_STOP:    k = WR_STOP;
                default:     k = WR_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/autocfg_id_regs.sv
module autocfg_id_regs
    import autocfg_pkg::*;
#(
    parameter logic [15:0] MFG_ID     = 16'h1E5A,
    parameter logic [7:0]  PRODUCT_ID = 8'h11
) (
    input  board_cfg_t  cfg,
    input  logic [8:0]  addr,
    input  logic        done,
    output logic [7:0]  rdata
);

    size_enc_t  enc;
    logic [7:0] reg_val;
    logic       true_polarity;
    logic [3:0] nib;

    assign enc = encode_size(cfg.size_exp);

    always_comb begin
        reg_val       = 8'h00;
        true_polarity = 1'b0;
        case (addr[7:0])
            OFS_TYPE: begin
                reg_val       = {2'b10, cfg.ram, 2'b00, enc.code};
                true_polarity = 1'b1;
            end
            OFS_PROD:   reg_val = PRODUCT_ID;
            OFS_FLAGS:  reg_val = {cfg.ram, 1'b0, enc.ext, 1'b1, 4'h0};
            OFS_MFG_HI: reg_val = MFG_ID[15:8];
            OFS_MFG_LO: reg_val = MFG_ID[7:0];
            default:    reg_val = 8'h00;
        endcase
    end

    always_comb begin
        nib = addr[8] ? reg_val[3:0] : reg_val[7:4];
        if (!true_polarity) nib = ~nib;
        if (done)           nib = 4'hF;
        rdata = {nib, 4'h0};
    end

endmodule

// File: rtl/autocfg_base_builder.sv
module autocfg_base_builder
    import autocfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_kind_e    kind,
    input  logic [15:0] wdata,
    output logic        complete,
    output logic [31:0] final_base
);

    logic [15:0] work_hi;
    logic        nib_latch;
    logic [15:0] next_hi;
    logic        next_latch;

    always_comb begin
        next_hi    = work_hi;
        next_latch = nib_latch;
        complete   = 1'b0;
        case (kind)
            WR_NIB_LO: begin
                next_hi[3:0] = wdata[7:4];
                next_latch   = 1'b1;
            end
            WR_NIB_HI: begin
                next_hi[11:8] = wdata[7:4];
                next_latch    = 1'b1;
            end
            WR_ADDR_LO: begin
                if (nib_latch) next_hi[7:4] = wdata[7:4];
                else           next_hi[7:0] = wdata[7:0];
                next_latch = 1'b0;
            end
            WR_ADDR_HI_B: begin
                next_hi[15:8] = wdata[7:0];
                complete      = 1'b1;
            end
            WR_ADDR_HI_W: begin
                next_hi  = wdata;
                complete = 1'b1;
            end
            WR_STOP:  complete = 1'b1;
            default:  ;
        endcase
        final_base = {next_hi, 16'h0000};
    end

    always_ff @(posedge clk) begin
        if (rst || complete) begin
            work_hi   <= '0;
            nib_latch <= 1'b0;
        end else begin
            work_hi   <= next_hi;
            nib_latch <= next_latch;
        end
    end

endmodule

// File: rtl/autocfg_board_seq.sv
module autocfg_board_seq #(
    parameter int NUM_BOARDS = 2,
    localparam int IDX_W = (NUM_BOARDS > 1) ? $clog2(NUM_BOARDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             complete,
    input  logic [31:0]      final_base,
    output logic [IDX_W-1:0] cur_idx,
    output logic             all_done,
    output logic             cfg_valid,
    output logic [IDX_W-1:0] cfg_index,
    output logic [31:0]      cfg_base
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BOARDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            all_done  <= 1'b0;
            cfg_valid <= 1'b0;
            cfg_index <= '0;
            cfg_base  <= '0;
        end else begin
            cfg_valid <= complete;
            if (complete) begin
                cfg_index <= cur_idx;
                cfg_base  <= final_base;
                if (cur_idx == LAST_IDX) all_done <= 1'b1;
                else                     cur_idx  <= cur_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/autocfg_responder.sv
module autocfg_responder
    import autocfg_pkg::*;
#(
    parameter int          NUM_BOARDS = 2,
    parameter logic [15:0] MFG_ID     = 16'h1E5A,
    parameter logic [7:0]  PRODUCT_ID = 8'h11,
    localparam int IDX_W = (NUM_BOARDS > 1) ? $clog2(NUM_BOARDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [8:0]                   addr,
    input  logic                         wr_en,
    input  logic                         wr_word,
    input  logic [15:0]                  wdata,
    output logic [7:0]                   rdata,
    input  logic [NUM_BOARDS-1:0]        board_ram,
    input  logic [NUM_BOARDS*SIZE_W-1:0] board_size_exp,
    output logic                         cfg_valid,
    output logic [IDX_W-1:0]             cfg_index,
    output logic [31:0]                  cfg_base,
    output logic                         all_done,
    output logic                         word_err
);

    logic [IDX_W-1:0] cur_idx;
    board_cfg_t       cur_cfg;
    wr_kind_e         kind;
    logic             complete;
    logic [31:0]      final_base;

    assign cur_cfg.ram      = board_ram[cur_idx];
    assign cur_cfg.size_exp = board_size_exp[cur_idx*SIZE_W +: SIZE_W];

    assign kind = (wr_en && !all_done) ? classify_write(wr_word, addr[7:0]) : WR_NONE;

    autocfg_id_regs #(
        .MFG_ID     (MFG_ID),
        .PRODUCT_ID (PRODUCT_ID)
    ) u_id (
        .cfg   (cur_cfg),
        .addr  (addr),
        .done  (all_done),
        .rdata (rdata)
    );

    autocfg_base_builder u_base (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .wdata      (wdata),
        .complete   (complete),
        .final_base (final_base)
    );

    autocfg_board_seq #(
        .NUM_BOARDS (NUM_BOARDS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .complete   (complete),
        .final_base (final_base),
        .cur_idx    (cur_idx),
        .all_done   (all_done),
        .cfg_valid  (cfg_valid),
        .cfg_index  (cfg_index),
        .cfg_base   (cfg_base)
    );

    always_ff @(posedge clk) begin
        if (rst) word_err <= 1'b0;
        else     word_err <= (kind == WR_BAD_WORD);
    end

endmodule

// File: rtl/autocfg_responder_chk.sv
module autocfg_responder_chk #(
    parameter int NUM_BOARDS = 2,
    localparam int IDX_W = (NUM_BOARDS > 1) ? $clog2(NUM_BOARDS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [8:0]       addr,
    input logic             wr_en,
    input logic             wr_word,
    input logic [7:0]       rdata,
    input logic             cfg_valid,
    input logic [IDX_W-1:0] cfg_index,
    input logic [31:0]      cfg_base,
    input logic             all_done,
    input logic             word_err
);

    p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rdata[3:0] == 4'h0);

    p_base_low_zero_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> cfg_base[15:0] == 16'h0000);

    p_publish_cause_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> $past(wr_en && !all_done));

    p_index_range_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> int'(cfg_index) < NUM_BOARDS);

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        all_done |=> all_done);

    p_quiet_after_done_r11: assert property (@(posedge clk) disable iff (rst)
        all_done |=> !cfg_valid);

    p_done_reads_r11: assert property (@(posedge clk) disable iff (rst)
        all_done |-> rdata == 8'hF0);

    p_err_cause_r12: assert property (@(posedge clk) disable iff (rst)
        word_err |-> $past(wr_en && wr_word && addr[7:0] != 8'h40 && !all_done));

endmodule

bind autocfg_responder autocfg_responder_chk #(.NUM_BOARDS(NUM_BOARDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .rdata     (rdata),
    .cfg_valid (cfg_valid),
    .cfg_index (cfg_index),
    .cfg_base  (cfg_base),
    .all_done  (all_done),
    .word_err  (word_err)
);

// File: tb/autocfg_responder_test.sv
`timescale 1ns/1ps
module autocfg_responder_test;

    localparam int          NB   = 3;
    localparam int          IW   = 2;
    localparam logic [15:0] MFG  = 16'hC3A7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [8:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic          wr_word = 1'b0;
    logic [15:0]   wdata = '0;
    logic [7:0]    rdata;
    logic [NB-1:0] board_ram = '0;
    logic [NB*5-1:0] board_size_exp = '0;
    logic          cfg_valid;
    logic [IW-1:0] cfg_index;
    logic [31:0]   cfg_base;
    logic          all_done;
    logic          word_err;

    int n_vec = 0;
    int n_bad = 0;

    // bench model
    logic [31:0] m_base;
    bit          m_latch;
    int          m_idx;
    bit          m_done;

    always #2.5 clk = ~clk;

    autocfg_responder #(.NUM_BOARDS(NB), .MFG_ID(MFG), .PRODUCT_ID(8'h11)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_word(wr_word),
        .wdata(wdata), .rdata(rdata), .board_ram(board_ram),
        .board_size_exp(board_size_exp), .cfg_valid(cfg_valid),
        .cfg_index(cfg_index), .cfg_base(cfg_base), .all_done(all_done),
        .word_err(word_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3 size code from the exponent rules
    function automatic logic [3:0] exp_size(input int e); // {ext, code}
        if (e < 6)        return {1'b0, 3'd1};
        else if (e <= 12) return {1'b0, 3'(e - 5)};
        else if (e == 13) return {1'b0, 3'd0};
        else if (e <= 20) return {1'b1, 3'(e - 14)};
        else              return {1'b1, 3'd2};
    endfunction

    function automatic logic [7:0] exp_read(input logic [8:0] a);
        logic [7:0] v;
        logic [3:0] sz;
        logic [3:0] n;
        bit ram;
        bit is_type;
        if (m_done) return 8'hF0;
        ram = board_ram[m_idx];
        sz  = exp_size(int'(board_size_exp[m_idx*5 +: 5]));
        is_type = (a[7:0] == 8'h00);
        case (a[7:0])
            8'h00: v = {2'b10, ram, 2'b00, sz[2:0]};
            8'h04: v = 8'h11;
            8'h08: v = {ram, 1'b0, sz[3], 1'b1, 4'h0};
            8'h10: v = MFG[15:8];
            8'h14: v = MFG[7:0];
            default: v = 8'h00;
        endcase
        n = a[8] ? v[3:0] : v[7:4];
        if (!is_type) n = ~n;
        return {n, 4'h0};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_base = '0; m_latch = 0; m_idx = 0; m_done = 0;
    endtask

    task automatic do_read(input logic [8:0] a, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(req, {24'h0, rdata}, {24'h0, exp_read(a)});
    endtask

    task automatic do_write(input bit word, input logic [7:0] ofs, input logic [15:0] d, input string req);
        bit comp = 0;
        bit bad = 0;
        int idx0 = m_idx;
        logic [31:0] pub = m_base;
        if (!m_done) begin
            if (word) begin
                if (ofs == 8'h40) begin pub = {d, 16'h0}; comp = 1; end
                else bad = 1;
            end else begin
                case (ofs)
                    8'h44: begin pub[19:16] = d[7:4]; m_latch = 1; end
                    8'h50: begin pub[27:24] = d[7:4]; m_latch = 1; end
                    8'h48: begin
                        if (m_latch) pub[23:20] = d[7:4];
                        else         pub[23:16] = d[7:0];
                        m_latch = 0;
                    end
                    8'h40: begin pub[31:24] = d[7:0]; comp = 1; end
                    8'h4C: comp = 1;
                    default: ;
                endcase
            end
            m_base = pub;
            if (comp) begin
                m_base = '0; m_latch = 0;
                if (m_idx == NB - 1) m_done = 1; else m_idx++;
            end
        end
        @(negedge clk);
        wr_en = 1'b1; wr_word = word; addr = {1'b0, ofs}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wr_word = 1'b0;
        check({req, " valid"}, {31'h0, cfg_valid}, {31'h0, comp});
        if (comp) begin
            check({req, " base"}, cfg_base, pub);
            check({req, " index"}, {30'h0, cfg_index}, idx0);
        end
        check("R12 word_err", {31'h0, word_err}, {31'h0, bad});
        check("R11 all_done", {31'h0, all_done}, {31'h0, m_done});
    endtask

    function automatic logic [7:0] pick_ofs();
        int r = $urandom_range(0, 9);
        case (r)
            0: return 8'h40;
            1: return 8'h44;
            2: return 8'h48;
            3: return 8'h4C;
            4: return 8'h50;
            5: return 8'h48;
            6: return 8'h44;
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin : watchdog
        #600000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        board_ram = 3'b101;
        board_size_exp = {5'd25, 5'd14, 5'd13};
        do_reset();
        // R13 reset state
        check("R13 all_done", {31'h0, all_done}, 0);
        check("R13 cfg_valid", {31'h0, cfg_valid}, 0);
        check("R13 word_err", {31'h0, word_err}, 0);

        // R1 R2 R3 R4 R5 directed reads of board 0
        do_read(9'h000, "R2 R3 type hi");
        do_read(9'h100, "R2 R3 type lo");
        do_read(9'h004, "R5 product hi");
        do_read(9'h104, "R5 product lo");
        do_read(9'h008, "R4 flags hi");
        do_read(9'h108, "R4 flags lo");
        do_read(9'h010, "R5 mfg hi");
        do_read(9'h114, "R5 mfg lo");
        do_read(9'h018, "R5 serial");
        do_read(9'h12C, "R5 diag");
        do_read(9'h160, "R5 reserved");

        // board 0: R6 nibble then R7 latched address-low, then R8 byte high
        do_write(0, 8'h44, 16'h00B0, "R6 nib lo");
        do_write(0, 8'h48, 16'h00D5, "R7 latched lo");
        do_write(0, 8'h48, 16'h0036, "R7 full lo");
        do_write(0, 8'h50, 16'h00E0, "R6 nib hi");
        do_write(0, 8'h40, 16'h0091, "R8 R9 byte high");
        // R9 reads follow board 1 (ram=0, size 16MB extended)
        do_read(9'h000, "R9 R3 next board type hi");
        do_read(9'h100, "R9 R3 next board type lo");
        do_read(9'h008, "R9 R4 next board flags");

        // board 1: R12 then R8 word
        do_write(1, 8'h48, 16'h1234, "R12 bad word");
        do_write(1, 8'h40, 16'h4321, "R8 word high");

        // board 2: R10 stop keeps partial base
        do_write(0, 8'h48, 16'h007E, "R10 partial lo");
        do_write(0, 8'h4C, 16'h0000, "R10 stop");
        // R11 done behaviour
        do_read(9'h000, "R11 done read type");
        do_read(9'h104, "R11 done read product");
        do_write(0, 8'h40, 16'h00FF, "R11 write after done");
        do_write(1, 8'h10, 16'hFFFF, "R11 word after done");

        // size sweep R3 R4
        do_reset();
        for (int e = 0; e < 32; e++) begin
            board_size_exp[4:0] = 5'(e);
            do_read(9'h100, "R3 size sweep");
            do_read(9'h008, "R4 ext sweep");
        end

        // random phase
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 99);
            if (op < 10) begin
                board_ram = NB'($urandom());
                board_size_exp = (NB*5)'($urandom());
            end
            if (m_done && op < 30) do_reset();
            else if (op < 45) begin
                logic [8:0] a = 9'($urandom_range(0, 511));
                if (op < 38) a[7:0] = a[7:0] & 8'h1C;
                do_read(a, "R1 R2 R5 random read");
            end else if (op < 55) begin
                do_write(1, ($urandom_range(0, 2) == 0) ? pick_ofs() : 8'h40,
                         16'($urandom()), "R8 R12 random word");
            end else begin
                do_write(0, pick_ofs(), 16'($urandom()), "R6 R7 R9 R10 random byte");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule